// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the serial slave front end of a 512-byte nonvolatile memory. It runs entirely in the system clock domain. It samples chip select, serial clock and serial data in, and recovers the serial clock edges from those samples. It shifts in an 8-bit instruction, most significant bit first, and recognises six commands. For array accesses it also collects a one-byte address. The ninth address bit travels inside the instruction itself, in bit 3.

Read commands stream bytes from an external byte array, starting at the selected address. Status reads stream the status byte. Write commands fill a page buffer with data. When the host ends the transfer on a clean byte boundary, the block hands a program request to a separate write-cycle controller. That controller answers with a one-cycle acknowledge when the program cycle is over. Serial clock idle-low (mode 0) and idle-high (mode 3) are both handled, because input is taken on rising serial clock edges and output moves on falling edges.

Top module: `spi_mem_engine`

## Requirements
- R1: After reset `so_oe` and `wr_req` are 0 and the write-enable latch is clear.
- R2: After reset, no instruction is accepted until `cs_n` has gone from high to low. Bits clocked while `cs_n` was already low at reset are ignored.
- R3: `so_oe` is 0 whenever `cs_n` is high (one clock of sampling lag).
- R4: Opcode 0x06 sets the write-enable latch. Opcode 0x04 clears it.
- R5: Opcode 0x05 streams the status byte, repeated for as long as clocks continue. Bits 7:4 are 0, bits 3:2 are `bp_in`, bit 1 is the write-enable latch and bit 0 is the write-in-progress flag.
- R6: Opcode `0000_A011` followed by an address byte reads from address {A, address byte}. The first data bit, MSB first, appears after the falling edge that follows the last address bit. The address increments after each byte and wraps from 0x1FF to 0x000. Reads do not stop at page boundaries.
- R7: Opcode `0000_A010` followed by an address byte stores data bytes into a 4-byte page at lane address[1:0]. The lane then increments modulo 4, so a fifth byte overwrites the first. `wr_page` is address[8:2]. Mask bit i marks lane i, which is `wr_data[8i+7:8i]`.
- R8: A program request is raised only if `cs_n` rises after a whole number of data bytes, with at least one byte. A rise at any other bit position raises no request.
- R9: A write or status write issued while the write-enable latch is clear raises no request.
- R10: Opcode 0x01 followed by a data byte, with the latch set and a clean byte-boundary deselect, raises a request with `wr_kind`=1 and that byte on `wr_status`.
- R11: While `wr_req` is high, the write-in-progress flag reads 1 and only opcode 0x05 is acted on. Every other opcode has no effect and drives no output.
- R12: `wr_req` and its payload hold until `wr_ack`. The acknowledge drops `wr_req` and clears the write-enable latch.
- R13: An unrecognised opcode makes the block ignore everything up to the next deselect.
- R14: Reads and writes behave the same with serial clock idle low and idle high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| bp_in | input | 2 | Block-protect level reported in status |
| rd_addr | output | 9 | Byte array read address |
| rd_data | input | 8 | Byte array read data |
| wr_req | output | 1 | Program request, held until acknowledged |
| wr_kind | output | 1 | 0 = array page, 1 = status byte |
| wr_page | output | 7 | Page number of the array write |
| wr_data | output | 32 | Page bytes, lane i in bits 8i+7:8i |
| wr_mask | output | 4 | Lanes written in the transfer |
| wr_status | output | 8 | Status byte to program |
| wr_ack | input | 1 | One-cycle completion from the write controller |

## Verification
The bench builds the block with its default page size of four bytes (`PAGE_LG2` = 2) and the fixed 9-bit address. With that setting, a page overrun needs only five data bytes, and the top-of-array read wrap is one short read from 0x1FE. The serial clock half-period is four system clocks and the acknowledge comes 1500 clocks after the request. That delay leaves room for whole status reads, a latch-clear attempt and a read attempt while the program cycle is still pending.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam int ADDR_W = 9;

    localparam logic [7:0] OP_SET_WE  = 8'h06;
    localparam logic [7:0] OP_CLR_WE  = 8'h04;
    localparam logic [7:0] OP_GET_SR  = 8'h05;
    localparam logic [7:0] OP_PUT_SR  = 8'h01;
    localparam logic [2:0] OP_RD_TAIL = 3'b011;
    localparam logic [2:0] OP_WR_TAIL = 3'b010;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_SET_WE,
        CMD_CLR_WE,
        CMD_GET_SR,
        CMD_PUT_SR,
        CMD_READ,
        CMD_WRITE
    } cmd_e;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_RDOUT,
        PH_WRIN,
        PH_SRIN,
        PH_SROUT,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic sel;
        logic sel_fall;
        logic sel_rise;
        logic clk_rise;
        logic clk_fall;
        logic din;
    } pin_ev_t;

    function automatic cmd_e decode_op(input logic [7:0] op);
        cmd_e c;
        c = CMD_NONE;
        if (op == OP_SET_WE)
            c = CMD_SET_WE;
        else if (op == OP_CLR_WE)
            c = CMD_CLR_WE;
        else if (op == OP_GET_SR)
            c = CMD_GET_SR;
        else if (op == OP_PUT_SR)
            c = CMD_PUT_SR;
        else if (op[7:4] == 4'h0 && op[2:0] == OP_RD_TAIL)
            c = CMD_READ;
        else if (op[7:4] == 4'h0 && op[2:0] == OP_WR_TAIL)
            c = CMD_WRITE;
        return c;
    endfunction

    function automatic logic [7:0] status_byte(input logic [1:0] bp,
                                               input logic       wel,
                                               input logic       wip);
        return {4'b0000, bp, wel, wip};
    endfunction

endpackage

// File: rtl/spi_pin_sampler.sv
module spi_pin_sampler
    import spi_mem_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    sck,
    input  logic    si,
    output pin_ev_t ev
);

    logic cs1, cs2, sck1, sck2, si1;

    // Reset to "selected" so a chip select held low through reset is not
    // mistaken for a fresh falling edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            cs1  <= 1'b0;
            cs2  <= 1'b0;
            sck1 <= 1'b0;
            sck2 <= 1'b0;
            si1  <= 1'b0;
        end else begin
            cs1  <= cs_n;
            cs2  <= cs1;
            sck1 <= sck;
            sck2 <= sck1;
            si1  <= si;
        end
    end

    always_comb begin
        ev.sel      = ~cs1;
        ev.sel_fall = ~cs1 & cs2;
        ev.sel_rise = cs1 & ~cs2;
        ev.clk_rise = ~cs1 & sck1 & ~sck2;
        ev.clk_fall = ~cs1 & ~sck1 & sck2;
        ev.din      = si1;
    end

endmodule

// File: rtl/spi_page_buffer.sv
module spi_page_buffer #(
    parameter int PAGE_LG2 = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clear,
    input  logic [PAGE_LG2-1:0]           start_lane,
    input  logic                          push,
    input  logic [7:0]                    din,
    output logic [(8<<PAGE_LG2)-1:0]      data,
    output logic [(1<<PAGE_LG2)-1:0]      mask
);

    localparam int LANES = 1 << PAGE_LG2;

    logic [PAGE_LG2-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (clear)
            ptr <= start_lane;
        else if (push)
            ptr <= ptr + 1'b1;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [7:0] lane_q;
        logic       lane_v;
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q <= 8'h00;
                lane_v <= 1'b0;
            end else if (clear) begin
                lane_v <= 1'b0;
            end else if (push && ptr == PAGE_LG2'(i)) begin
                lane_q <= din;
                lane_v <= 1'b1;
            end
        end
        assign data[8*i +: 8] = lane_q;
        assign mask[i]        = lane_v;
    end

endmodule

// File: rtl/spi_cmd_core.sv
module spi_cmd_core
    import spi_mem_pkg::*;
#(
    parameter int PAGE_LG2 = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  pin_ev_t                    ev,
    input  logic [1:0]                 bp_in,
    input  logic [7:0]                 rd_data,
    input  logic                       wr_ack,
    input  logic [(1<<PAGE_LG2)-1:0]   buf_mask,
    output logic                       so,
    output logic                       so_oe,
    output logic [ADDR_W-1:0]          rd_addr,
    output logic                       buf_clear,
    output logic [PAGE_LG2-1:0]        buf_lane,
    output logic                       buf_push,
    output logic [7:0]                 buf_din,
    output logic                       wr_req,
    output logic                       wr_kind,
    output logic [ADDR_W-PAGE_LG2-1:0] wr_page,
    output logic [7:0]                 wr_status
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = 1;

    logic              armed;
    phase_e            phase;
    cmd_e              cmd;
    logic [2:0]        bit_cnt;
    logic [6:0]        in_sh;
    logic              a_hi;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        out_sh;
    logic              out_vld;
    logic              wel;
    logic [7:0]        sr_byte;
    logic              sr_seen;

    logic [7:0] rx_byte;
    logic       byte_done;
    cmd_e       op_cmd;
    logic       busy;
    logic       load_out;
    logic       commit_arr;
    logic       commit_sr;

    always_comb begin
        rx_byte    = {in_sh, ev.din};
        byte_done  = armed & ev.clk_rise & (bit_cnt == 3'd7);
        op_cmd     = decode_op(rx_byte);
        busy       = wr_req;
        load_out   = armed & ev.clk_fall & (bit_cnt == 3'd0) &
                     ((phase == PH_RDOUT) | (phase == PH_SROUT));
        commit_arr = armed & ev.sel_rise & (phase == PH_WRIN) &
                     (bit_cnt == 3'd0) & (|buf_mask) & wel & ~busy;
        commit_sr  = armed & ev.sel_rise & (phase == PH_SRIN) &
                     (bit_cnt == 3'd0) & sr_seen & wel & ~busy;
        buf_clear  = byte_done & (phase == PH_ADDR) & (cmd == CMD_WRITE);
        buf_lane   = rx_byte[PAGE_LG2-1:0];
        buf_push   = byte_done & (phase == PH_WRIN);
        buf_din    = rx_byte;
        so         = out_sh[7];
        so_oe      = out_vld & ev.sel;
        rd_addr    = addr;
        wr_page    = addr[ADDR_W-1:PAGE_LG2];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed     <= 1'b0;
            phase     <= PH_OPC;
            cmd       <= CMD_NONE;
            bit_cnt   <= 3'd0;
            in_sh     <= 7'd0;
            a_hi      <= 1'b0;
            addr      <= '0;
            out_sh    <= 8'h00;
            out_vld   <= 1'b0;
            wel       <= 1'b0;
            sr_byte   <= 8'h00;
            sr_seen   <= 1'b0;
            wr_req    <= 1'b0;
            wr_kind   <= 1'b0;
            wr_status <= 8'h00;
        end else begin
            if (ev.sel_fall) begin
                armed   <= 1'b1;
                phase   <= PH_OPC;
                bit_cnt <= 3'd0;
                out_vld <= 1'b0;
                sr_seen <= 1'b0;
            end else if (ev.sel_rise) begin
                phase   <= PH_OPC;
                bit_cnt <= 3'd0;
                in_sh   <= 7'd0;
                out_vld <= 1'b0;
                sr_seen <= 1'b0;
                if (commit_arr) begin
                    wr_req  <= 1'b1;
                    wr_kind <= 1'b0;
                end else if (commit_sr) begin
                    wr_req    <= 1'b1;
                    wr_kind   <= 1'b1;
                    wr_status <= sr_byte;
                end
            end else if (armed && ev.sel) begin
                if (ev.clk_rise) begin
                    in_sh   <= rx_byte[6:0];
                    bit_cnt <= bit_cnt + 3'd1;
                    if (byte_done) begin
                        case (phase)
                            PH_OPC: begin
                                if (busy && op_cmd != CMD_GET_SR) begin
                                    phase <= PH_SKIP;
                                end else begin
                                    case (op_cmd)
                                        CMD_SET_WE: begin wel <= 1'b1; phase <= PH_SKIP; end
                                        CMD_CLR_WE: begin wel <= 1'b0; phase <= PH_SKIP; end
                                        CMD_GET_SR: phase <= PH_SROUT;
                                        CMD_PUT_SR: phase <= PH_SRIN;
                                        CMD_READ, CMD_WRITE: begin
                                            a_hi  <= rx_byte[3];
                                            cmd   <= op_cmd;
                                            phase <= PH_ADDR;
                                        end
                                        default: phase <= PH_SKIP;
                                    endcase
                                end
                            end
                            PH_ADDR: begin
                                addr  <= {a_hi, rx_byte};
                                phase <= (cmd == CMD_READ) ? PH_RDOUT : PH_WRIN;
                            end
                            PH_SRIN: begin
                                sr_byte <= rx_byte;
                                sr_seen <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end else if (ev.clk_fall) begin
                    if (load_out) begin
                        out_vld <= 1'b1;
                        if (phase == PH_RDOUT) begin
                            out_sh <= rd_data;
                            addr   <= addr + ADDR_ONE;
                        end else begin
                            out_sh <= status_byte(bp_in, wel, wr_req);
                        end
                    end else if (out_vld) begin
                        out_sh <= {out_sh[6:0], 1'b0};
                    end
                end
            end
            if (wr_req && wr_ack) begin
                wr_req <= 1'b0;
                wel    <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine
    import spi_mem_pkg::*;
#(
    parameter int PAGE_LG2 = 2
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 cs_n,
    input  logic                                 sck,
    input  logic                                 si,
    output logic                                 so,
    output logic                                 so_oe,
    input  logic [1:0]                           bp_in,
    output logic [spi_mem_pkg::ADDR_W-1:0]       rd_addr,
    input  logic [7:0]                           rd_data,
    output logic                                 wr_req,
    output logic                                 wr_kind,
    output logic [spi_mem_pkg::ADDR_W-PAGE_LG2-1:0] wr_page,
    output logic [(8<<PAGE_LG2)-1:0]             wr_data,
    output logic [(1<<PAGE_LG2)-1:0]             wr_mask,
    output logic [7:0]                           wr_status,
    input  logic                                 wr_ack
);

    pin_ev_t             ev;
    logic                buf_clear;
    logic [PAGE_LG2-1:0] buf_lane;
    logic                buf_push;
    logic [7:0]          buf_din;

    spi_pin_sampler u_pins (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sck  (sck),
        .si   (si),
        .ev   (ev)
    );

    spi_page_buffer #(.PAGE_LG2(PAGE_LG2)) u_page (
        .clk        (clk),
        .rst        (rst),
        .clear      (buf_clear),
        .start_lane (buf_lane),
        .push       (buf_push),
        .din        (buf_din),
        .data       (wr_data),
        .mask       (wr_mask)
    );

    spi_cmd_core #(.PAGE_LG2(PAGE_LG2)) u_core (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .bp_in     (bp_in),
        .rd_data   (rd_data),
        .wr_ack    (wr_ack),
        .buf_mask  (wr_mask),
        .so        (so),
        .so_oe     (so_oe),
        .rd_addr   (rd_addr),
        .buf_clear (buf_clear),
        .buf_lane  (buf_lane),
        .buf_push  (buf_push),
        .buf_din   (buf_din),
        .wr_req    (wr_req),
        .wr_kind   (wr_kind),
        .wr_page   (wr_page),
        .wr_status (wr_status)
    );

endmodule

// File: rtl/spi_mem_engine_chk.sv
module spi_mem_engine_chk #(
    parameter int PAGE_LG2 = 2
) (
    input logic                                    clk,
    input logic                                    rst,
    input logic                                    cs_n,
    input logic                                    so_oe,
    input logic                                    wr_req,
    input logic                                    wr_ack,
    input logic                                    wr_kind,
    input logic [spi_mem_pkg::ADDR_W-PAGE_LG2-1:0] wr_page,
    input logic [(8<<PAGE_LG2)-1:0]                wr_data,
    input logic [(1<<PAGE_LG2)-1:0]                wr_mask,
    input logic [7:0]                              wr_status
);

    a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!wr_req && !so_oe));

    a_r3_so_off_when_deselected: assert property (@(posedge clk) disable iff (rst)
        $past(cs_n) |-> !so_oe);

    a_r12_req_held: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ack) |=> wr_req);

    a_r12_ack_clears_req: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wr_ack) |=> !wr_req);

    a_r12_payload_stable: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_ack) |=> ($stable(wr_data) && $stable(wr_mask) &&
                                 $stable(wr_page) && $stable(wr_kind) &&
                                 $stable(wr_status)));

    a_r8_mask_present: assert property (@(posedge clk) disable iff (rst)
        ($rose(wr_req) && !wr_kind) |-> (wr_mask != '0));

endmodule

bind spi_mem_engine spi_mem_engine_chk #(.PAGE_LG2(PAGE_LG2)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .so_oe     (so_oe),
    .wr_req    (wr_req),
    .wr_ack    (wr_ack),
    .wr_kind   (wr_kind),
    .wr_page   (wr_page),
    .wr_data   (wr_data),
    .wr_mask   (wr_mask),
    .wr_status (wr_status)
);

// File: tb/spi_mem_engine_bench.sv
module spi_mem_engine_bench;

    localparam int HALF    = 4;
    localparam int ACK_DLY = 1500;

    logic        clk = 1'b0;
    logic        rst;
    logic        cs_n, sck, si;
    logic        so, so_oe;
    logic [1:0]  bp_reg;
    logic [8:0]  rd_addr;
    logic [7:0]  rd_data;
    logic        wr_req, wr_kind, wr_ack;
    logic [6:0]  wr_page;
    logic [31:0] wr_data;
    logic [3:0]  wr_mask;
    logic [7:0]  wr_status;

    logic [7:0] mem     [512];
    logic [7:0] ref_mem [512];
    logic [7:0] wbuf    [8];
    logic [1:0] bp_exp;
    bit         mode3;
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 0;

    always #2 clk = ~clk;

    assign rd_data = mem[rd_addr];

    spi_mem_engine u_spi_mem_engine (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
        .so(so), .so_oe(so_oe), .bp_in(bp_reg),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_req(wr_req), .wr_kind(wr_kind), .wr_page(wr_page),
        .wr_data(wr_data), .wr_mask(wr_mask), .wr_status(wr_status),
        .wr_ack(wr_ack)
    );

    function automatic logic [7:0] init_byte(input int a);
        return 8'((a * 29 + 7) ^ (a >> 3));
    endfunction

    function automatic logic [7:0] exp_sr(input logic [1:0] bp, input logic wel, input logic wip);
        return {4'b0000, bp, wel, wip};
    endfunction

    function automatic logic [3:0] exp_mask(input logic [8:0] a, input int n);
        logic [3:0] m;
        m = 4'b0000;
        for (int k = 0; k < n && k < 4; k++) m[(a[1:0] + k) % 4] = 1'b1;
        return m;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // harness write-cycle controller and byte array
    initial begin
        wr_ack = 1'b0;
        for (int a = 0; a < 512; a++) mem[a] = init_byte(a);
        forever begin
            tick(1);
            if (wr_req) begin
                tick(ACK_DLY);
                if (wr_kind) bp_reg = wr_status[3:2];
                else
                    for (int l = 0; l < 4; l++)
                        if (wr_mask[l]) mem[{wr_page, 2'(l)}] = wr_data[8*l +: 8];
                wr_ack = 1'b1;
                tick(1);
                wr_ack = 1'b0;
                tick(1);
            end
        end
    end

    task automatic sel();
        sck = mode3;
        tick(2);
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic desel();
        if (!mode3) sck = 1'b0;
        tick(HALF);
        cs_n = 1'b1;
        tick(HALF);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] rx, inout logic saw);
        rx = 8'h00;
        for (int i = 0; i < nb; i++) begin
            sck = 1'b0;
            si  = tx[7-i];
            tick(HALF);
            rx[7-i] = so;
            saw     = saw | so_oe;
            sck = 1'b1;
            tick(HALF);
        end
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] rx;
        logic saw;
        saw = 1'b0;
        sel();
        xfer(op, 8, rx, saw);
        desel();
    endtask

    task automatic rdsr(output logic [7:0] st);
        logic [7:0] rx;
        logic saw;
        saw = 1'b0;
        sel();
        xfer(8'h05, 8, rx, saw);
        xfer(8'h00, 8, st, saw);
        xfer(8'h00, 8, rx, saw);
        desel();
        chk("R5 repeat", rx, st);
        chk("R3", so_oe, 1'b0);
    endtask

    task automatic read_chk(input string req, input logic [8:0] a, input int n);
        logic [7:0] rx;
        logic saw;
        logic [8:0] p;
        saw = 1'b0;
        sel();
        xfer({4'h0, a[8], 3'b011}, 8, rx, saw);
        xfer(a[7:0], 8, rx, saw);
        for (int k = 0; k < n; k++) begin
            p = a + 9'(k);
            xfer(8'h00, 8, rx, saw);
            chk(req, rx, ref_mem[p]);
        end
        desel();
    endtask

    task automatic write_seq(input logic [8:0] a, input int n, input int extra);
        logic [7:0] rx;
        logic saw;
        saw = 1'b0;
        sel();
        xfer({4'h0, a[8], 3'b010}, 8, rx, saw);
        xfer(a[7:0], 8, rx, saw);
        for (int k = 0; k < n; k++) xfer(wbuf[k], 8, rx, saw);
        if (extra > 0) xfer(8'hA5, extra, rx, saw);
        desel();
    endtask

    task automatic ref_page(input logic [8:0] a, input int n);
        logic [1:0] lane;
        lane = a[1:0];
        for (int k = 0; k < n; k++) begin
            ref_mem[{a[8:2], lane}] = wbuf[k];
            lane = lane + 2'd1;
        end
    endtask

    task automatic wait_idle();
        while (wr_req) tick(1);
        tick(2);
    endtask

    initial begin
        tick(190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] st, rx;
        logic saw;
        void'($urandom(32'd1234));
        for (int a = 0; a < 512; a++) ref_mem[a] = init_byte(a);
        bp_reg = 2'b00; bp_exp = 2'b00;
        mode3 = 1'b0;
        rst = 1'b1; cs_n = 1'b0; sck = 1'b0; si = 1'b0;
        tick(5);
        rst = 1'b0;
        tick(2);
        chk("R1 so_oe", so_oe, 1'b0);
        chk("R1 wr_req", wr_req, 1'b0);

        // R2: WREN sent while chip select was low since reset
        saw = 1'b0;
        xfer(8'h06, 8, rx, saw);
        cs_n = 1'b1;
        tick(HALF);
        rdsr(st);
        chk("R2 unarmed WREN", st, exp_sr(bp_exp, 1'b0, 1'b0));

        // R4
        cmd1(8'h06); rdsr(st);
        chk("R4 set", st, exp_sr(bp_exp, 1'b1, 1'b0));
        cmd1(8'h04); rdsr(st);
        chk("R4 clear", st, exp_sr(bp_exp, 1'b0, 1'b0));

        // R13: unknown opcode, then WREN in same selection
        mode3 = 1'b1;
        saw = 1'b0;
        sel();
        xfer(8'h50, 8, rx, saw);
        xfer(8'h06, 8, rx, saw);
        xfer(8'h00, 8, rx, saw);
        desel();
        chk("R13 no output", saw, 1'b0);
        rdsr(st);
        chk("R13 ignored WREN", st, exp_sr(bp_exp, 1'b0, 1'b0));
        saw = 1'b0;
        sel();
        xfer(8'h0E, 8, rx, saw);
        xfer(8'h00, 8, rx, saw);
        desel();
        chk("R13 0x0E", saw | wr_req, 1'b0);

        // R9: write with latch clear
        mode3 = 1'b0;
        wbuf[0] = 8'h3C;
        write_seq(9'h010, 1, 0);
        chk("R9 no request", wr_req, 1'b0);
        read_chk("R9 unchanged", 9'h010, 1);

        // R7: three bytes at lane 1 of page 0x41
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        cmd1(8'h06);
        write_seq(9'h105, 3, 0);
        chk("R7 req", wr_req, 1'b1);
        chk("R7 kind", wr_kind, 1'b0);
        chk("R7 page", wr_page, 7'h41);
        chk("R7 mask", wr_mask, 4'b1110);
        chk("R7 lane1", wr_data[15:8], 8'h11);
        ref_page(9'h105, 3);
        wait_idle();
        rdsr(st);
        chk("R12 latch cleared", st, exp_sr(bp_exp, 1'b0, 1'b0));
        read_chk("R7 readback", 9'h104, 4);

        // R11: busy window
        mode3 = 1'b1;
        wbuf[0] = 8'h9D;
        cmd1(8'h06);
        write_seq(9'h040, 1, 0);
        ref_page(9'h040, 1);
        rdsr(st);
        chk("R11 wip", st, exp_sr(bp_exp, 1'b1, 1'b1));
        cmd1(8'h04);
        rdsr(st);
        chk("R11 WRDI ignored", st, exp_sr(bp_exp, 1'b1, 1'b1));
        saw = 1'b0;
        sel();
        xfer(8'h03, 8, rx, saw);
        xfer(8'h00, 8, rx, saw);
        xfer(8'h00, 8, rx, saw);
        desel();
        chk("R11 read ignored", saw, 1'b0);
        chk("R12 still pending", wr_req, 1'b1);
        wait_idle();
        rdsr(st);
        chk("R12 done", st, exp_sr(bp_exp, 1'b0, 1'b0));

        // R7 page overrun: six bytes from lane 2
        mode3 = 1'b0;
        for (int k = 0; k < 6; k++) wbuf[k] = 8'hC0 + 8'(k);
        cmd1(8'h06);
        write_seq(9'h0FE, 6, 0);
        chk("R7 wrap mask", wr_mask, 4'b1111);
        chk("R7 wrap page", wr_page, 7'h3F);
        chk("R7 wrap lane2", wr_data[23:16], 8'hC4);
        ref_page(9'h0FE, 6);
        wait_idle();
        read_chk("R6 R7 across page", 9'h0FC, 6);

        // R8: abandoned writes
        wbuf[0] = 8'h77;
        cmd1(8'h06);
        write_seq(9'h020, 1, 3);
        chk("R8 partial bits", wr_req, 1'b0);
        write_seq(9'h020, 0, 0);
        chk("R8 no data", wr_req, 1'b0);
        write_seq(9'h020, 0, 5);
        chk("R8 partial first", wr_req, 1'b0);
        read_chk("R8 unchanged", 9'h020, 1);
        cmd1(8'h04);

        // R10 + R5
        cmd1(8'h06);
        saw = 1'b0;
        sel();
        xfer(8'h01, 8, rx, saw);
        xfer(8'h0C, 8, rx, saw);
        desel();
        chk("R10 req", wr_req, 1'b1);
        chk("R10 kind", wr_kind, 1'b1);
        chk("R10 data", wr_status, 8'h0C);
        bp_exp = 2'b11;
        wait_idle();
        rdsr(st);
        chk("R5 bp field", st, exp_sr(bp_exp, 1'b0, 1'b0));

        // R6: top-of-array wrap, both clock idle levels
        read_chk("R6 wrap", 9'h1FE, 4);
        mode3 = 1'b1;
        read_chk("R14 wrap mode3", 9'h1FF, 3);

        // random mix
        for (int it = 0; it < 20; it++) begin
            logic [8:0] a;
            int n;
            mode3 = 1'($urandom % 2);
            a = 9'($urandom % 512);
            n = 1 + int'($urandom % 6);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            cmd1(8'h06);
            write_seq(a, n, 0);
            chk("R14 R7 req", wr_req, 1'b1);
            chk("R14 R7 mask", wr_mask, exp_mask(a, n));
            ref_page(a, n);
            wait_idle();
            read_chk("R14 R6 readback", {a[8:2], 2'b00}, 5);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule